// File: doc/BRIEF.md
# Cache-Line Instruction Slicer

This block is the part of an instruction fetch stage that turns a buffered instruction-cache line into a group of decoded-stage instructions. Each thread has its own line buffer and line tag. When a fetch is requested for a thread, the block aligns the fetch PC down to a line boundary. If that line is not the one the thread already holds, the block issues a line request in the same cycle. If the line is present, the block slices up to a fixed number of 32-bit words out of it, starting at the word that the PC points to.

The candidate words and their PCs go out combinationally to an external predictor and classifier. That unit returns, for each slot, whether the word is a control instruction, whether it is predicted taken and its target, and whether it is a quiesce instruction. The block then sends a registered group to decode. Each group carries a valid mask, the words, their PCs, their predicted next PCs and their global sequence numbers.

A translation fault on a line miss turns into a single no-op that carries the fault code. New requests are held back while the cache is blocked, or while an interrupt is pending outside privileged mode.

Top module: `fetch_line_slicer`

## Requirements
- R1: On a fetch whose aligned address (PC with its low 6 bits cleared, for 64-byte lines) differs from the thread's recorded line, `req_valid` is high in that same cycle, with `req_addr` set to the aligned address and `req_tid` set to the thread.
- R2: A line is recorded per thread when its request is issued. No request is issued for a fetch whose aligned address equals that thread's recorded line. Another thread's recorded line does not count.
- R3: While `cache_blocked` is high, or while `irq_pending` is high and `priv_mode` is low, a missing line is not requested, and the fetch emits no group.
- R4: A fetch that hits a filled line emits its group on the clock edge after `fetch_go`. Slot 0 holds the word at index PC[5:2], and later slots hold the following words. Words are little-endian: fill byte i is `fill_data[8i+7:8i]`, and word j is `fill_data[32j+31:32j]`. The slot PC is the PC with its low 2 bits cleared plus 4 times the slot number.
- R5: A group stops at the end of the line or after 4 slots, whichever comes first. Valid slots are always contiguous from slot 0.
- R6: A slot's next PC is PC+4 unless `cls_ctrl` and `bp_taken` are both high for it, in which case it is `bp_target`. A predicted-taken slot is the last slot of its group. `out_next_pc` equals the next PC of the last valid slot.
- R7: A slot flagged by `cls_quiesce` is the last slot of its group, and `out_halt` is high with that group.
- R8: Sequence numbers start at 0 after reset. They are consecutive across the slots of a group and across groups, and all threads share them.
- R9: A fetch that would request a line while `fault_in` is high issues no request and records no line. Instead it emits one slot holding word 0x00000000 at the fetch PC, with `out_fault` high, `out_fault_code` equal to `fault_code`, next PC equal to PC+4, and one sequence number used.
- R10: A fill is accepted only for a thread with an outstanding request. A fetch that hits a recorded line that is not yet filled emits nothing and requests nothing.
- R11: After reset, no group is valid, no request is issued, and no thread holds a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_go | input | 1 | Fetch attempt this cycle |
| fetch_tid | input | $clog2(THREADS) | Thread of the attempt |
| fetch_pc | input | AW | Fetch PC |
| priv_mode | input | 1 | Attempt runs in privileged/physical mode |
| fault_in | input | 1 | Translation or bad-address fault for a miss |
| fault_code | input | FCW | Fault code to carry |
| cache_blocked | input | 1 | Cache cannot accept a request |
| irq_pending | input | 1 | Interrupt is pending |
| req_valid | output | 1 | Line request |
| req_addr | output | AW | Aligned line address |
| req_tid | output | $clog2(THREADS) | Requesting thread |
| fill_valid | input | 1 | Line data return |
| fill_tid | input | $clog2(THREADS) | Thread of the returned line |
| fill_data | input | LINE_BYTES*8 | Returned line, byte 0 in the low bits |
| cand_inst | output | WIDTH*32 | Candidate words per slot, to the predictor |
| cand_pc | output | WIDTH*AW | Candidate PCs per slot |
| cls_ctrl | input | WIDTH | Slot is a control instruction |
| cls_quiesce | input | WIDTH | Slot is a quiesce instruction |
| bp_taken | input | WIDTH | Slot is predicted taken |
| bp_target | input | WIDTH*AW | Predicted target per slot |
| out_valid | output | WIDTH | Valid slots of the group |
| out_inst | output | WIDTH*32 | Slot words |
| out_pc | output | WIDTH*AW | Slot PCs |
| out_npc | output | WIDTH*AW | Slot predicted next PCs |
| out_seq | output | WIDTH*SEQW | Slot sequence numbers |
| out_tid | output | $clog2(THREADS) | Thread of the group |
| out_fault | output | 1 | Group is a fault-carrying no-op |
| out_fault_code | output | FCW | Carried fault code |
| out_halt | output | 1 | Group ended on a quiesce instruction |
| out_next_pc | output | AW | Fetch PC to use next |

## Verification
The line request is combinational, so the bench samples `req_valid`, `req_addr` and `req_tid` one time unit after it drives `fetch_go` on a falling edge, before any clock edge has passed. The group, fault and halt outputs, and the next PC, come through one register. The bench reads them on the falling edge that follows the single rising edge after `fetch_go`. A fill takes effect on its rising edge and is visible to the very next fetch. The sweep covers every start word of a line, and the expected slots are computed from that start index, the width limit and the bench's own classification of the test words.

// File: rtl/fetch_line_slicer.sv
module fetch_line_slicer #(
  parameter int THREADS    = 2,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int WIDTH      = 4,
  parameter int SEQW       = 16,
  parameter int FCW        = 4,
  parameter logic [31:0] NOP_INST = 32'h0000_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fetch_go,
  input  logic [$clog2(THREADS)-1:0]    fetch_tid,
  input  logic [AW-1:0]                 fetch_pc,
  input  logic                          priv_mode,
  input  logic                          fault_in,
  input  logic [FCW-1:0]                fault_code,
  input  logic                          cache_blocked,
  input  logic                          irq_pending,
  output logic                          req_valid,
  output logic [AW-1:0]                 req_addr,
  output logic [$clog2(THREADS)-1:0]    req_tid,
  input  logic                          fill_valid,
  input  logic [$clog2(THREADS)-1:0]    fill_tid,
  input  logic [LINE_BYTES*8-1:0]       fill_data,
  output logic [WIDTH*32-1:0]           cand_inst,
  output logic [WIDTH*AW-1:0]           cand_pc,
  input  logic [WIDTH-1:0]              cls_ctrl,
  input  logic [WIDTH-1:0]              cls_quiesce,
  input  logic [WIDTH-1:0]              bp_taken,
  input  logic [WIDTH*AW-1:0]           bp_target,
  output logic [WIDTH-1:0]              out_valid,
  output logic [WIDTH*32-1:0]           out_inst,
  output logic [WIDTH*AW-1:0]           out_pc,
  output logic [WIDTH*AW-1:0]           out_npc,
  output logic [WIDTH*SEQW-1:0]         out_seq,
  output logic [$clog2(THREADS)-1:0]    out_tid,
  output logic                          out_fault,
  output logic [FCW-1:0]                out_fault_code,
  output logic                          out_halt,
  output logic [AW-1:0]                 out_next_pc
);
  localparam int OFFW  = $clog2(LINE_BYTES);
  localparam int WPL   = LINE_BYTES / 4;
  localparam int WIW   = $clog2(WPL);
  localparam int LBITS = LINE_BYTES * 8;
  localparam int TIDW  = $clog2(THREADS);

  logic [LBITS-1:0] line_q [THREADS];
  logic [AW-1:0]    tag_q  [THREADS];
  logic [THREADS-1:0] tag_v, data_ok;
  logic [SEQW-1:0]  seq_q;

  logic [AW-1:0]    aligned, pc_w;
  logic [LBITS-1:0] cur_line;
  logic             tag_hit, hold, want_req, take_fault, extract;
  logic [WIW-1:0]   start;

  assign aligned    = fetch_pc & ~AW'(LINE_BYTES - 1);
  assign pc_w       = {fetch_pc[AW-1:2], 2'b00};
  assign start      = fetch_pc[OFFW-1:2];
  assign cur_line   = line_q[fetch_tid];
  assign tag_hit    = tag_v[fetch_tid] && (tag_q[fetch_tid] == aligned);
  assign hold       = cache_blocked || (irq_pending && !priv_mode);
  assign want_req   = fetch_go && !tag_hit && !hold;
  assign take_fault = want_req && fault_in;
  assign extract    = fetch_go && tag_hit && data_ok[fetch_tid];

  assign req_valid = want_req && !fault_in;
  assign req_addr  = aligned;
  assign req_tid   = fetch_tid;

  logic [WIDTH-1:0]  in_line;
  logic [AW-1:0]     s_pc  [WIDTH];
  logic [AW-1:0]     s_npc [WIDTH];

  for (genvar k = 0; k < WIDTH; k++) begin : g_slot
    logic [WIW:0] widx;
    assign widx       = {1'b0, start} + (WIW+1)'(k);
    assign in_line[k] = widx < (WIW+1)'(WPL);
    assign cand_inst[k*32 +: 32] = cur_line[widx[WIW-1:0]*32 +: 32];
    assign s_pc[k]    = pc_w + AW'(4 * k);
    assign cand_pc[k*AW +: AW] = s_pc[k];
    assign s_npc[k]   = (cls_ctrl[k] && bp_taken[k]) ? bp_target[k*AW +: AW]
                                                     : s_pc[k] + AW'(4);
  end

  logic [WIDTH-1:0] slot_v;
  logic             halt_c, live;
  logic [AW-1:0]    last_npc;

  always_comb begin
    live     = extract;
    slot_v   = '0;
    halt_c   = 1'b0;
    last_npc = pc_w + AW'(4);
    for (int k = 0; k < WIDTH; k++) begin
      slot_v[k] = live && in_line[k];
      if (slot_v[k]) begin
        last_npc = s_npc[k];
        if (cls_quiesce[k]) halt_c = 1'b1;
        if ((cls_ctrl[k] && bp_taken[k]) || cls_quiesce[k]) live = 1'b0;
      end else begin
        live = 1'b0;
      end
    end
  end

  logic [SEQW-1:0] n_emit;
  assign n_emit = take_fault ? SEQW'(1) : SEQW'($countones(slot_v));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_v   <= '0;
      data_ok <= '0;
      seq_q   <= '0;
      for (int t = 0; t < THREADS; t++) begin
        tag_q[t]  <= '0;
        line_q[t] <= '0;
      end
    end else begin
      seq_q <= seq_q + n_emit;
      if (fill_valid && tag_v[fill_tid] && !data_ok[fill_tid]) begin
        line_q[fill_tid]  <= fill_data;
        data_ok[fill_tid] <= 1'b1;
      end
      if (req_valid) begin
        tag_q[fetch_tid]   <= aligned;
        tag_v[fetch_tid]   <= 1'b1;
        data_ok[fetch_tid] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= '0;
      out_inst       <= '0;
      out_pc         <= '0;
      out_npc        <= '0;
      out_seq        <= '0;
      out_tid        <= '0;
      out_fault      <= 1'b0;
      out_fault_code <= '0;
      out_halt       <= 1'b0;
      out_next_pc    <= '0;
    end else begin
      out_tid        <= fetch_tid;
      out_fault      <= take_fault;
      out_fault_code <= take_fault ? fault_code : '0;
      out_halt       <= halt_c;
      out_next_pc    <= last_npc;
      for (int k = 0; k < WIDTH; k++) begin
        out_seq[k*SEQW +: SEQW] <= seq_q + SEQW'(k);
        out_pc[k*AW +: AW]      <= s_pc[k];
        out_npc[k*AW +: AW]     <= s_npc[k];
        out_inst[k*32 +: 32]    <= cand_inst[k*32 +: 32];
      end
      out_valid <= slot_v;
      if (take_fault) begin
        out_valid            <= WIDTH'(1);
        out_inst[31:0]       <= NOP_INST;
        out_npc[AW-1:0]      <= pc_w + AW'(4);
      end
    end
  end

  assert_blocked_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cache_blocked |-> !req_valid);
  assert_irq_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !priv_mode) |-> !req_valid);
  assert_no_rerequest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !(req_valid && req_tid == $past(req_tid) && req_addr == $past(req_addr)));
  assert_out_follows_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid != '0) |-> $past(fetch_go));
  assert_slots_packed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid & (out_valid + WIDTH'(1))) == '0));
  assert_fault_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_valid == WIDTH'(1)));
  assert_seq_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[1] |-> (out_seq[2*SEQW-1:SEQW] == out_seq[SEQW-1:0] + SEQW'(1)));
  assert_req_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && !tag_hit && !hold && !fault_in) |-> req_valid);

endmodule

// File: tb/fetch_line_slicer_tb.sv
module fetch_line_slicer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic fetch_go = 0, priv_mode = 0, fault_in = 0, cache_blocked = 0, irq_pending = 0;
  logic [0:0] fetch_tid = 0, fill_tid = 0;
  logic [31:0] fetch_pc = 0;
  logic [3:0] fault_code = 0;
  logic fill_valid = 0;
  logic [511:0] fill_data = '0;
  logic req_valid;
  logic [31:0] req_addr;
  logic [0:0] req_tid, out_tid;
  logic [W*32-1:0] cand_inst, out_inst;
  logic [W*32-1:0] cand_pc, out_pc, out_npc, bp_target;
  logic [W-1:0] cls_ctrl, cls_quiesce, bp_taken, out_valid;
  logic [W*16-1:0] out_seq;
  logic out_fault, out_halt;
  logic [3:0] out_fault_code;
  logic [31:0] out_next_pc;

  for (genvar k = 0; k < W; k++) begin : g_pred
    assign cls_ctrl[k]    = cand_inst[k*32+28 +: 4] == 4'hB;
    assign cls_quiesce[k] = cand_inst[k*32+28 +: 4] == 4'hF;
    assign bp_taken[k]    = cand_inst[k*32];
    assign bp_target[k*32 +: 32] = {8'h00, cand_inst[k*32+2 +: 22], 2'b00};
  end

  fetch_line_slicer dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .fetch_tid(fetch_tid),
    .fetch_pc(fetch_pc), .priv_mode(priv_mode), .fault_in(fault_in),
    .fault_code(fault_code), .cache_blocked(cache_blocked), .irq_pending(irq_pending),
    .req_valid(req_valid), .req_addr(req_addr), .req_tid(req_tid),
    .fill_valid(fill_valid), .fill_tid(fill_tid), .fill_data(fill_data),
    .cand_inst(cand_inst), .cand_pc(cand_pc), .cls_ctrl(cls_ctrl),
    .cls_quiesce(cls_quiesce), .bp_taken(bp_taken), .bp_target(bp_target),
    .out_valid(out_valid), .out_inst(out_inst), .out_pc(out_pc), .out_npc(out_npc),
    .out_seq(out_seq), .out_tid(out_tid), .out_fault(out_fault),
    .out_fault_code(out_fault_code), .out_halt(out_halt), .out_next_pc(out_next_pc)
  );

  int n_checks = 0, n_fail = 0;
  int exp_seq = 0;
  logic [31:0] img [16];
  logic seen_req;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic default_img(input logic [31:0] base);
    for (int i = 0; i < 16; i++) img[i] = {4'h1, base[27:0] + 28'(4*i)};
  endtask

  task automatic do_fill(input logic [0:0] tid);
    @(negedge clk);
    fill_valid = 1; fill_tid = tid;
    for (int i = 0; i < 16; i++)
      for (int b = 0; b < 4; b++) fill_data[(4*i+b)*8 +: 8] = img[i][b*8 +: 8];
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_fetch(input logic [0:0] tid, input logic [31:0] pc,
                          input logic prv, input logic flt, input logic [3:0] code);
    @(negedge clk);
    fetch_go = 1; fetch_tid = tid; fetch_pc = pc; priv_mode = prv;
    fault_in = flt; fault_code = code;
    #1 seen_req = req_valid;
    if (req_valid) begin
      chk("R1", "req_addr", 64'(req_addr), 64'(pc & 32'hFFFF_FFC0));
      chk("R1", "req_tid", 64'(req_tid), 64'(tid));
    end
    @(negedge clk);
    fetch_go = 0; fault_in = 0; priv_mode = 0;
  endtask

  task automatic chk_none(input string req);
    chk(req, "out_valid", 64'(out_valid), 64'd0);
  endtask

  task automatic chk_group(input logic [31:0] pc, input logic [0:0] tid);
    logic [3:0] ev;
    logic live, halt;
    logic [31:0] npc, last, ins, spc;
    int w;
    live = 1; halt = 0; ev = '0; last = {pc[31:2], 2'b00} + 4;
    for (int k = 0; k < W; k++) begin
      w = int'(pc[5:2]) + k;
      if (live && w < 16) begin
        ev[k] = 1;
        ins = img[w];
        spc = {pc[31:2], 2'b00} + 32'(4*k);
        npc = (ins[31:28] == 4'hB && ins[0]) ? {8'h00, ins[23:2], 2'b00} : spc + 4;
        chk("R4", "slot inst", 64'(out_inst[k*32 +: 32]), 64'(ins));
        chk("R4", "slot pc", 64'(out_pc[k*32 +: 32]), 64'(spc));
        chk("R6", "slot npc", 64'(out_npc[k*32 +: 32]), 64'(npc));
        chk("R8", "slot seq", 64'(out_seq[k*16 +: 16]), 64'(16'(exp_seq + k)));
        last = npc;
        if (ins[31:28] == 4'hF) halt = 1;
        if ((ins[31:28] == 4'hB && ins[0]) || ins[31:28] == 4'hF) live = 0;
      end else live = 0;
    end
    chk("R5", "out_valid", 64'(out_valid), 64'(ev));
    chk("R6", "out_next_pc", 64'(out_next_pc), 64'(last));
    chk("R7", "out_halt", 64'(out_halt), 64'(halt));
    chk("R4", "out_tid", 64'(out_tid), 64'(tid));
    chk("R9", "out_fault", 64'(out_fault), 64'd0);
    exp_seq += $countones(ev);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11", "reset out_valid", 64'(out_valid), 64'd0);
    chk("R11", "reset req_valid", 64'(req_valid), 64'd0);

    default_img(32'h1000);
    do_fetch(0, 32'h1000, 0, 0, 0);
    chk("R1", "miss request", 64'(seen_req), 64'd1);
    chk_none("R1");
    do_fetch(0, 32'h1008, 0, 0, 0);
    chk("R10", "unfilled no req", 64'(seen_req), 64'd0);
    chk_none("R10");
    do_fill(0);
    for (int w = 0; w < 16; w++) begin
      do_fetch(0, 32'h1000 + 32'(4*w) + 32'(w % 4), 0, 0, 0);
      chk("R2", "hit no req", 64'(seen_req), 64'd0);
      chk_group(32'h1000 + 32'(4*w) + 32'(w % 4), 0);
    end

    fill_data = '0;
    default_img(32'h7000);
    do_fill(1);
    do_fetch(1, 32'h1000, 0, 0, 0);
    chk("R2", "other thread misses", 64'(seen_req), 64'd1);
    do_fetch(1, 32'h1004, 0, 0, 0);
    chk("R10", "stray fill ignored", 64'(out_valid), 64'd0);
    default_img(32'h1000);
    do_fill(1);
    do_fetch(1, 32'h1030, 0, 0, 0);
    chk_group(32'h1030, 1);

    cache_blocked = 1;
    do_fetch(0, 32'h2000, 0, 0, 0);
    chk("R3", "blocked no req", 64'(seen_req), 64'd0);
    chk_none("R3");
    cache_blocked = 0; irq_pending = 1;
    do_fetch(0, 32'h2000, 0, 0, 0);
    chk("R3", "irq no req", 64'(seen_req), 64'd0);
    chk_none("R3");
    do_fetch(0, 32'h2000, 1, 0, 0);
    chk("R3", "irq privileged req", 64'(seen_req), 64'd1);
    irq_pending = 0;

    default_img(32'h2000);
    img[1] = 32'hB000_3001;
    img[2] = 32'hB000_4000;
    img[5] = 32'hF000_0000;
    do_fill(0);
    do_fetch(0, 32'h2000, 0, 0, 0);
    chk("R6", "taken stops", 64'(out_valid), 64'h3);
    chk_group(32'h2000, 0);
    do_fetch(0, 32'h2008, 0, 0, 0);
    chk("R7", "quiesce stops", 64'(out_valid), 64'hF);
    chk_group(32'h2008, 0);
    do_fetch(0, 32'h2010, 0, 0, 0);
    chk("R7", "quiesce halt", 64'(out_halt), 64'd1);
    chk_group(32'h2010, 0);

    do_fetch(0, 32'h5006, 0, 1, 4'h5);
    chk("R9", "fault no req", 64'(seen_req), 64'd0);
    chk("R9", "fault valid", 64'(out_valid), 64'h1);
    chk("R9", "fault flag", 64'(out_fault), 64'd1);
    chk("R9", "fault code", 64'(out_fault_code), 64'h5);
    chk("R9", "fault inst", 64'(out_inst[31:0]), 64'd0);
    chk("R9", "fault pc", 64'(out_pc[31:0]), 64'h5004);
    chk("R9", "fault npc", 64'(out_npc[31:0]), 64'h5008);
    chk("R8", "fault seq", 64'(out_seq[15:0]), 64'(16'(exp_seq)));
    exp_seq += 1;
    do_fetch(0, 32'h5004, 0, 0, 0);
    chk("R9", "line not recorded", 64'(seen_req), 64'd1);
    default_img(32'h5000);
    do_fill(0);
    do_fetch(0, 32'h503C, 0, 0, 0);
    chk_group(32'h503C, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule